// File: doc/BRIEF.md
# Edge-Latched Interrupt Vector Responder

This block sits on the device side of a processor interrupt input that is sensitive to level and is answered with two acknowledge pulses. Seven request lines, each active low, combine into one request. A rising edge on that combined request sets a pending flop. The flop drives the interrupt output and holds it high until the processor answers. A short request pulse therefore becomes a held level.

The processor acknowledges with two low pulses on its acknowledge strobe. On the first pulse the block does two things. It takes a snapshot of the request lines with bit 7 forced to 1, which gives FEH for line 0 and BFH for line 6. It also drops the interrupt output. During the second pulse, and at no other time, the block drives the snapshot onto the data byte and raises the drive enable. The pad ring's tri-state buffer uses that enable. While the enable is low the data output is held at 00H.

A new edge that arrives while a request is pending or being acknowledged is kept. It raises the interrupt output again once the second pulse ends. All inputs are synchronous to `clk_i`. Requests are edge-latched, so a line held low through an acknowledge does not retrigger.

Top module: `irq_vector_responder`

## Requirements
- R1: After reset (rst_ni low), intr_o is 0, data_oe_o is 0 and data_o is 00H.
- R2: The combined request is true when any bit of irq_n_i is 0. A rising edge of it, with nothing pending and no acknowledge in progress, makes intr_o 1 on the following clock.
- R3: intr_o stays 1 after all request lines return high, until an acknowledge arrives.
- R4: The first falling edge of inta_n_i, sampled on a clock, clears intr_o on that same clock.
- R5: data_oe_o is 1 only during the second low pulse of inta_n_i. It rises on the clock that samples that pulse's falling edge and falls on the clock that samples inta_n_i high again. Whenever data_oe_o is 0, data_o is 00H.
- R6: The vector is {1, irq_n_i[6:0]}, with bit 7 as 1 and bit k equal to line k. It is sampled on the clock of the first acknowledge edge, so single active lines 0..6 give FEH, FDH, FBH, F7H, EFH, DFH and BFH. Line changes between the two pulses do not alter it.
- R7: A request edge is held if it arrives while intr_o is 1 or an acknowledge is in progress. When the second pulse ends, intr_o becomes 1 again on the clock where data_oe_o falls.
- R8: A request line held low through a whole acknowledge, with no new edge, leaves intr_o at 0 afterwards.
- R9: Asserting rst_ni low while a request is pending clears intr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_n_i | input | 7 | Request lines, active low |
| inta_n_i | input | 1 | Acknowledge strobe from the processor, active low |
| intr_o | output | 1 | Held interrupt request to the processor |
| data_o | output | 8 | Vector byte, 00H while not driven |
| data_oe_o | output | 1 | Drive enable for the data byte |

## Verification
The assertions assume that acknowledge pulses come in pairs, each at least one clock long and separated by at least one clock of inta_n_i high. They also assume that the inputs change only away from the sampling edge. The stimulus drives every input one time unit after a rising clock edge. It holds each acknowledge pulse low for two clocks and high for two. It starts a new acknowledge only after the previous pair has ended. A behavioural model in the bench follows edge, pulse and queue events with plain variables and is compared on every falling clock edge.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  localparam int unsigned NUM_LINES = 7;
  localparam int unsigned VEC_W     = 8;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_ack_sequencer.sv
module irq_ack_sequencer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inta_n_i,
  output logic first_fire_o,
  output logic release_o,
  output logic busy_o,
  output logic drive_o
);
  logic inta_prev_q, phase_q, sec_q;
  logic fall;

  assign fall         = inta_prev_q & ~inta_n_i;
  assign first_fire_o = fall & ~phase_q;
  assign release_o    = sec_q & inta_n_i;
  assign busy_o       = phase_q | sec_q;
  assign drive_o      = sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inta_prev_q <= 1'b1;
      phase_q     <= 1'b0;
      sec_q       <= 1'b0;
    end else begin
      inta_prev_q <= inta_n_i;
      if (fall) phase_q <= ~phase_q;
      if (fall && phase_q) sec_q <= 1'b1;
      else if (inta_n_i)   sec_q <= 1'b0;
    end
  end

  // R5
  oe_after_inta_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q |-> !$past(inta_n_i));
  // R5
  ack_phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({phase_q, sec_q}));
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch
  import irq_vector_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_n_i,
  input  logic                 first_fire_i,
  input  logic                 release_i,
  input  logic                 ack_busy_i,
  output logic                 pend_o
);
  logic req, req_prev_q, req_rise, pend_q, held_q;

  assign req      = ~&irq_n_i;
  assign req_rise = req & ~req_prev_q;
  assign pend_o   = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_prev_q <= 1'b0;
      pend_q     <= 1'b0;
      held_q     <= 1'b0;
    end else begin
      req_prev_q <= req;
      if (first_fire_i) begin
        pend_q <= 1'b0;
        if (req_rise) held_q <= 1'b1;
      end else if (release_i) begin
        pend_q <= held_q | req_rise;
        held_q <= 1'b0;
      end else if (req_rise) begin
        if (pend_q || ack_busy_i) held_q <= 1'b1;
        else                      pend_q <= 1'b1;
      end
    end
  end

  // R2
  pend_set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(pend_q) && pend_q) |-> $past(req_rise | held_q));
  // R7
  requeue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i && held_q) |=> pend_q);
endmodule

// File: rtl/irq_vector_capture.sv
module irq_vector_capture
  import irq_vector_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_n_i,
  input  logic                 capture_i,
  input  logic                 drive_i,
  output vec_t                 data_o
);
  vec_t vec_q, vec_d;

  always_comb begin
    vec_d = '1;
    vec_d[NUM_LINES-1:0] = irq_n_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        vec_q <= '0;
    else if (capture_i) vec_q <= vec_d;
  end

  assign data_o = drive_i ? vec_q : '0;

  // R6
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_i && $past(drive_i)) |-> $stable(data_o));
endmodule

// File: rtl/irq_vector_responder.sv
module irq_vector_responder
  import irq_vector_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_n_i,
  input  logic                 inta_n_i,
  output logic                 intr_o,
  output logic [VEC_W-1:0]     data_o,
  output logic                 data_oe_o
);
  logic first_fire, release_ack, ack_busy, drive;

  irq_ack_sequencer u_seq (
    .clk_i, .rst_ni, .inta_n_i,
    .first_fire_o(first_fire), .release_o(release_ack),
    .busy_o(ack_busy), .drive_o(drive)
  );

  irq_edge_latch u_latch (
    .clk_i, .rst_ni, .irq_n_i,
    .first_fire_i(first_fire), .release_i(release_ack),
    .ack_busy_i(ack_busy), .pend_o(intr_o)
  );

  irq_vector_capture u_vec (
    .clk_i, .rst_ni, .irq_n_i,
    .capture_i(first_fire), .drive_i(drive), .data_o(data_o)
  );

  assign data_oe_o = drive;

  // R4
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_fire |=> !intr_o);
endmodule

// File: tb/irq_vector_responder_tb.sv
module irq_vector_responder_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0, inta_n = 1;
  logic [6:0] irq_n = 7'h7F;
  logic       intr;
  logic [7:0] data;
  logic       oe;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_responder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_n_i(irq_n), .inta_n_i(inta_n),
    .intr_o(intr), .data_o(data), .data_oe_o(oe));

  // behavioural reference
  bit m_intr, m_queued, m_oe, last_req, last_inta;
  int pulses;
  logic [7:0] m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_intr = 0; m_queued = 0; m_oe = 0; pulses = 0;
      last_req = 0; last_inta = 1; m_vec = 0;
    end else begin
      bit req, req_edge, ack_edge, busy;
      req      = (irq_n != 7'h7F);
      req_edge = req && !last_req;
      ack_edge = last_inta && !inta_n;
      busy     = m_intr || pulses == 1 || m_oe;
      if (ack_edge && pulses == 0) begin
        m_vec = {1'b1, irq_n}; m_intr = 0; pulses = 1;
        if (req_edge) m_queued = 1;
      end else if (ack_edge) begin
        m_oe = 1; pulses = 0;
        if (req_edge) m_queued = 1;
      end else if (m_oe && inta_n) begin
        m_oe = 0; m_intr = m_queued || req_edge; m_queued = 0;
      end else if (req_edge) begin
        if (busy) m_queued = 1; else m_intr = 1;
      end
      last_req = req; last_inta = inta_n;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    logic [7:0] exp_d;
    exp_d = m_oe ? m_vec : 8'h00;
    tests++;
    if (intr !== m_intr || oe !== m_oe || data !== exp_d) begin
      fails++;
      $display("FAIL R2/R4/R5 model: intr=%b oe=%b data=%h expected intr=%b oe=%b data=%h",
               intr, oe, data, m_intr, m_oe, exp_d);
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic sample;
    @(negedge clk);
  endtask

  // two acknowledge pulses; optional line change between them
  task automatic do_ack(input logic [7:0] exp_vec, input logic [6:0] mid_irq,
                        input bit change_mid, input string tag);
    inta_n = 0; tick(); sample();
    chk({7'd0, intr}, 8'd0, {tag, " R4 intr cleared"});
    chk({7'd0, oe}, 8'd0, {tag, " R5 no drive on first pulse"});
    #1 tick(); inta_n = 1;
    if (change_mid) irq_n = mid_irq;
    tick(); sample();
    chk({7'd0, oe}, 8'd0, {tag, " R5 no drive between pulses"});
    chk(data, 8'h00, {tag, " R5 data zero"});
    #1 tick(); inta_n = 0; tick(); sample();
    chk({7'd0, oe}, 8'd1, {tag, " R5 drive on second pulse"});
    chk(data, exp_vec, {tag, " R6 vector"});
    #1 tick(); inta_n = 1; tick(); sample();
    chk({7'd0, oe}, 8'd0, {tag, " R5 drive ends"});
    #1;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    tick(3); sample();
    chk({6'd0, intr, oe}, 8'd0, "R1 reset outputs");
    chk(data, 8'h00, "R1 reset data");
    #1 rst_n = 1; tick(2);

    // R2 R3: edge on line 0 latches, held after release
    irq_n = 7'b1111110; tick(); sample();
    chk({7'd0, intr}, 8'd1, "R2 intr raised");
    #1 irq_n = 7'h7F; tick(4); sample();
    chk({7'd0, intr}, 8'd1, "R3 intr held");
    #1 irq_n = 7'b1111110; tick();
    // vector captured with line 0 low; mid change to line 3 ignored (R6)
    do_ack(8'hFE, 7'b1110111, 1, "R6 capture");
    irq_n = 7'h7F; tick(3);

    // R6: every single line
    for (int k = 0; k < 7; k++) begin
      logic [6:0] pat;
      pat = 7'h7F & ~(7'd1 << k);
      irq_n = pat; tick(2); sample();
      chk({7'd0, intr}, 8'd1, "R2 line request");
      #1 do_ack({1'b1, pat}, 7'h7F, 0, "R6 line");
      irq_n = 7'h7F; tick(3);
    end

    // R7: second edge while pending is queued
    irq_n = 7'b1111011; tick(2);
    irq_n = 7'h7F; tick(2);
    irq_n = 7'b1011111; tick(2);
    do_ack(8'hDF, 7'h7F, 0, "R7 first");
    sample();
    chk({7'd0, intr}, 8'd1, "R7 requeued intr");
    #1 irq_n = 7'b1111101; tick();
    do_ack(8'hFD, 7'h7F, 0, "R7 second");
    sample();
    chk({7'd0, intr}, 8'd0, "R8 no retrigger with line held");
    #1 tick(3); sample();
    chk({7'd0, intr}, 8'd0, "R8 still idle");
    #1 irq_n = 7'h7F; tick(2);

    // R9: reset while pending
    irq_n = 7'b0111111; tick(2); sample();
    chk({7'd0, intr}, 8'd1, "R9 pending before reset");
    #1 rst_n = 0; #2; sample();
    chk({7'd0, intr}, 8'd0, "R9 cleared by reset");
    chk({7'd0, oe}, 8'd0, "R1 drive low in reset");
    #1 irq_n = 7'h7F; tick(); rst_n = 1; tick(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule